// File: doc/BRIEF.md
# Latchable 64-bit Counter

This block keeps a 64-bit counter that advances on every clock edge where the time-base strobe is high. Software cannot read the running counter directly. It reads two captured 32-bit words, one for the lower half and one for the upper half, plus a control word. All three sit behind a simple 32-bit register port.

To read the time, software writes the control word with the snapshot bit set. The whole 64-bit count is copied into both word registers in one cycle, so the two halves always belong together. Software can also set a clear bit to zero both words. Either command can be issued alone, or both in the same write. Neither command bit is ever stored. Software may also write either word register directly.

Top module: `snapshot_counter`

## Requirements
- R1: The internal counter resets to zero. It increments by one at each clock edge where `tick` is high and holds at edges where `tick` is low.
- R2: A write to the control word (address 2) with bit 0 (snapshot) set and bit 1 clear loads the counter value from the write cycle. Bits [31:0] go to the low word (address 0) and bits [63:32] go to the high word (address 1). The new values are readable in the next cycle.
- R3: A write to the control word with bit 1 (clear) set and bit 0 clear zeroes both word registers.
- R4: A write to the control word with both bits 0 and 1 set acts as a snapshot followed by a clear, so both words read back as zero.
- R5: A write to address 0 or address 1 loads `wdata` into that word register and leaves the other word unchanged.
- R6: A read of the control word returns the bits last written to [31:2], with bits [1:0] always zero.
- R7: While `rst_n` is low, the low, high and control words read zero.
- R8: The word registers keep their value unless they are written directly, snapshotted or cleared. Clearing and direct writes do not disturb the running counter.
- R9: Address 3 always reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base strobe; the counter advances while high |
| wen | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 low word, 1 high word, 2 control, 3 unused |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |

## Verification
The counter is exercised with the strobe held high, alternating, and held low. The snapshot values show the exact count in each case, which separates an off-by-one capture from a missed or extra increment. Snapshot, clear and the combined command are each issued over distinct non-zero word contents written directly, so the bench can tell a missing clear from a wrong ordering of the two commands. Control writes carrying arbitrary upper bits, and writes to the unused address, show that command bits never stick and that stray writes leave both words intact.

// File: rtl/snapcnt_pkg.sv
package snapcnt_pkg;
  localparam int ADDR_W    = 2;
  localparam int BIT_SNAP  = 0;
  localparam int BIT_CLEAR = 1;
  localparam int CMD_BITS  = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;
endpackage

// File: rtl/snapcnt_timebase.sv
module snapcnt_timebase #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count_q
);
  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = count_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (tick) begin
      count_q <= count_d;
    end
  end
endmodule

// File: rtl/snapcnt_regs.sv
module snapcnt_regs
  import snapcnt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wen,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [2*DATA_W-1:0] snap,
  output logic [DATA_W-1:0]   lo_q,
  output logic [DATA_W-1:0]   hi_q,
  output logic [DATA_W-1:0]   ctrl_q
);
  localparam logic [DATA_W-1:0] CMD_MASK = DATA_W'((1 << CMD_BITS) - 1);

  logic [DATA_W-1:0] lo_d, hi_d, ctrl_d;
  logic              upd_en;

  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    ctrl_d = ctrl_q;
    upd_en = 1'b0;
    if (wen) begin
      unique case (sel_e'(addr))
        SEL_LO: begin
          lo_d   = wdata;
          upd_en = 1'b1;
        end
        SEL_HI: begin
          hi_d   = wdata;
          upd_en = 1'b1;
        end
        SEL_CTRL: begin
          ctrl_d = wdata & ~CMD_MASK;
          upd_en = 1'b1;
          // snapshot first, clear second
          if (wdata[BIT_SNAP]) begin
            lo_d = snap[DATA_W-1:0];
            hi_d = snap[2*DATA_W-1:DATA_W];
          end
          if (wdata[BIT_CLEAR]) begin
            lo_d = '0;
            hi_d = '0;
          end
        end
        default: upd_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      ctrl_q <= '0;
    end else if (upd_en) begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/snapshot_counter.sv
module snapshot_counter
  import snapcnt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0]  count_q;
  logic [DATA_W-1:0] lo_q, hi_q, ctrl_q;

  snapcnt_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .count_q (count_q)
  );

  snapcnt_regs #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wen    (wen),
    .addr   (addr),
    .wdata  (wdata),
    .snap   (count_q),
    .lo_q   (lo_q),
    .hi_q   (hi_q),
    .ctrl_q (ctrl_q)
  );

  always_comb begin
    unique case (sel_e'(addr))
      SEL_LO:   rdata = lo_q;
      SEL_HI:   rdata = hi_q;
      SEL_CTRL: rdata = ctrl_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/snapcnt_checker.sv
module snapcnt_checker #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                wen,
  input logic [1:0]          addr,
  input logic [DATA_W-1:0]   wdata,
  input logic [DATA_W-1:0]   rdata,
  input logic [2*DATA_W-1:0] count_q,
  input logic [DATA_W-1:0]   lo_q,
  input logic [DATA_W-1:0]   hi_q
);
  logic ctl_wr, word_touch;
  assign ctl_wr     = wen && addr == 2'd2;
  assign word_touch = wen && (addr == 2'd0 || addr == 2'd1 || (ctl_wr && (wdata[0] || wdata[1])));

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count_q == $past(count_q) + (2*DATA_W)'(1));
  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count_q));
  assert_snap_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && wdata[0] && !wdata[1] |=> {hi_q, lo_q} == $past(count_q));
  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && wdata[1] |=> lo_q == '0 && hi_q == '0);
  assert_ctrl_cmd_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 2'd2 |-> rdata[1:0] == 2'b00);
  assert_words_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !word_touch |=> $stable(lo_q) && $stable(hi_q));
  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 2'd3 |-> rdata == '0);
endmodule

bind snapshot_counter snapcnt_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/snapshot_counter_test.sv
module snapshot_counter_test;
  logic        clk = 1'b0;
  logic        rst_n, tick, wen;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;

  int errors = 0, checks = 0, tick_mode = 0, phase = 0;
  string tag = "R7";
  bit done = 0;

  longint unsigned m_cnt;
  logic [31:0] m_lo, m_hi, m_ctrl;

  snapshot_counter uut (.clk(clk), .rst_n(rst_n), .tick(tick), .wen(wen),
                        .addr(addr), .wdata(wdata), .rdata(rdata));

  always #5 clk = ~clk;

  // tick pattern: 0 always, 1 never, 2 alternating
  always @(negedge clk) begin
    phase = phase + 1;
    tick = (tick_mode == 0) ? 1'b1 : (tick_mode == 1) ? 1'b0 : phase[0];
  end

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_lo = 0; m_hi = 0; m_ctrl = 0;
    end else begin
      if (wen) begin
        if (addr == 2'd0) m_lo = wdata;
        else if (addr == 2'd1) m_hi = wdata;
        else if (addr == 2'd2) begin
          m_ctrl = wdata & ~32'h3;
          if (wdata[0]) begin m_lo = m_cnt[31:0]; m_hi = m_cnt[63:32]; end
          if (wdata[1]) begin m_lo = 0; m_hi = 0; end
        end
      end
      if (tick) m_cnt = m_cnt + 1;
    end
  end

  function automatic logic [31:0] expect_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_lo;
      2'd1: return m_hi;
      2'd2: return m_ctrl;
      default: return 32'h0;
    endcase
  endfunction

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    #1;
    if (!done) begin
      checks++;
      if (rdata !== expect_rd(addr)) begin
        errors++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", tag, addr, rdata, expect_rd(addr));
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wen = 1'b1; addr = a; wdata = d;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk); addr = a;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wen = 1'b0; addr = 2'd0; wdata = 32'h0; tick = 1'b0;
    tag = "R7"; rd(2'd0); rd(2'd1); rd(2'd2);
    @(negedge clk); rst_n = 1'b1;
    tag = "R1"; tick_mode = 0; repeat (20) @(negedge clk);
    tag = "R2"; wr(2'd2, 32'h1); rd(2'd0); rd(2'd1);
    tag = "R1"; tick_mode = 2; repeat (17) @(negedge clk);
    wr(2'd2, 32'h1); rd(2'd0);
    tick_mode = 1; wr(2'd2, 32'h1); rd(2'd0); wr(2'd2, 32'h1); rd(2'd0);
    tick_mode = 0;
    tag = "R5"; wr(2'd0, 32'hA5A5_1234); rd(2'd0); rd(2'd1);
    wr(2'd1, 32'hDEAD_BEEF); rd(2'd0); rd(2'd1);
    tag = "R2"; wr(2'd2, 32'h1); rd(2'd1); rd(2'd0);
    tag = "R3"; wr(2'd0, 32'h1111_2222); wr(2'd1, 32'h3333_4444);
    wr(2'd2, 32'h2); rd(2'd0); rd(2'd1);
    tag = "R4"; wr(2'd0, 32'h5555_6666); wr(2'd1, 32'h7777_8888);
    wr(2'd2, 32'h3); rd(2'd0); rd(2'd1);
    tag = "R6"; wr(2'd2, 32'hFFFF_FFF1); rd(2'd2); wr(2'd2, 32'h0000_00F2); rd(2'd2);
    tag = "R9"; wr(2'd0, 32'hCAFE_F00D); wr(2'd3, 32'hFFFF_FFFF); rd(2'd3);
    tag = "R8"; rd(2'd0); rd(2'd1); repeat (5) @(negedge clk);
    wr(2'd2, 32'h1); rd(2'd0); rd(2'd1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule